// File: doc/BRIEF.md
# Macro Instruction Expansion Sequencer

This block takes one assembler macro per input handshake and turns it into the machine words that a real 32-bit processor of the classic three-format family can execute. It emits those words one per cycle on a valid/ready stream, with a flag on the final word of each expansion. It sits behind a front end that has already parsed the macro and resolved its register numbers and its constant. It hands its words to whatever stores or issues them.

Five macros are handled: register copy, constant load, rotate right by a constant, no-operation, and unsigned add of a constant. The number of words a macro produces depends on its operand. A constant that fits a signed 16-bit field gives a single-word form. A wider constant is built from an upper half and a lower half. Register 1 is the only register an expansion may use as scratch. A macro code the block does not know, and a rotate by zero, both produce a single no-operation word and raise an error pulse.

Top module: `pseudo_expander`

## Requirements
- R1: `in_ready` is high when no expansion is pending. A macro accepted in cycle t has its first word presented with `out_valid` high in cycle t+1. `in_ready` stays low from the accept until the cycle after the final word is taken.
- R2: While `out_valid` is high and `out_ready` is low, `out_word` and `out_last` hold their values.
- R3: `out_last` is high on the final word of each expansion only, and `out_valid` is low in the cycle after that word is taken.
- R4: Macro code 0 (no-operation) emits the single word 0x00000000.
- R5: Macro code 1 (register copy) emits one word {6'h00, 5'd0, src, dst, 5'd0, 6'h20}.
- R6: Macro code 2 (constant load), when the constant fits, emits {6'h08, 5'd0, dst, value[15:0]}.
- R7: Macro code 2, when the constant does not fit, emits {6'h0F, 5'd0, dst, value[31:16]} and then {6'h0D, dst, dst, value[15:0]}.
- R8: Macro code 3 (rotate right) uses n = value[4:0] and emits three words in this order: {6'h00, 5'd0, dst, 5'd1, n, 6'h02}, then {6'h00, 5'd0, dst, dst, (32-n) mod 32, 6'h00}, then {6'h00, dst, 5'd1, dst, 5'd0, 6'h25}.
- R9: Macro code 4 (unsigned add of a constant), when the constant fits, emits {6'h09, src, dst, value[15:0]}.
- R10: Macro code 4, when the constant does not fit, emits {6'h0F, 5'd0, 5'd1, value[31:16]}, then {6'h0D, 5'd1, 5'd1, value[15:0]}, then {6'h00, src, 5'd1, dst, 5'd0, 6'h21}.
- R11: A constant fits when its signed 32-bit value lies in -32768..32767. So 32767 and -32768 take the single-word form, and 32768, 40000 and -32769 take the multi-word form.
- R12: Macro codes 5 to 7, and code 3 with n = 0, emit a single 0x00000000 word with `out_last` high. For these, `exp_error` is high for exactly one cycle: the first cycle in which that word is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A macro is offered |
| in_ready | output | 1 | Block can accept a macro |
| in_kind | input | 3 | Macro code (0 nop, 1 copy, 2 load, 3 rotate, 4 unsigned add) |
| in_dst | input | 5 | Destination register number |
| in_src | input | 5 | Source register number |
| in_value | input | 32 | Constant or rotate amount |
| out_valid | output | 1 | A machine word is presented |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Machine word |
| out_last | output | 1 | Final word of the expansion |
| exp_error | output | 1 | Unsupported macro or zero rotate, one-cycle pulse |

## Verification
A corrupted word index or length count shows up at once as a word out of order, a missing or repeated word, or `out_last` on the wrong word. It also shows as `in_ready` returning too early or too late, and every one of these is visible within the expansion that caused it. A wrong fit decision changes the first word emitted, so it appears in the cycle after the accept. Stalls are mixed into the stream so that a word which moves while blocked is caught in the stalled cycle itself.

// File: rtl/pe_pkg.sv
package pe_pkg;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned REG_W     = 5;
  localparam int unsigned IMM_W     = 16;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned SHAMT_W   = 5;
  localparam int unsigned FUNCT_W   = 6;
  localparam int unsigned KIND_W    = 3;
  localparam int unsigned MAX_WORDS = 3;
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);

  typedef enum logic [KIND_W-1:0] {
    MK_NOP   = 3'd0,
    MK_MOVE  = 3'd1,
    MK_LDIMM = 3'd2,
    MK_ROTR  = 3'd3,
    MK_ADDUI = 3'd4
  } macro_kind_e;

  localparam logic [REG_W-1:0] REG_ZERO    = 5'd0;
  localparam logic [REG_W-1:0] REG_SCRATCH = 5'd1;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [FUNCT_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNCT_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;

  typedef logic [INSN_W-1:0] word_t;

  function automatic word_t enc_r(input logic [REG_W-1:0] rs,
                                  input logic [REG_W-1:0] rt,
                                  input logic [REG_W-1:0] rd,
                                  input logic [SHAMT_W-1:0] sh,
                                  input logic [FUNCT_W-1:0] fn);
    return {OPC_RTYPE, rs, rt, rd, sh, fn};
  endfunction

  function automatic word_t enc_i(input logic [OPC_W-1:0] op,
                                  input logic [REG_W-1:0] rs,
                                  input logic [REG_W-1:0] rt,
                                  input logic [IMM_W-1:0] imm);
    return {op, rs, rt, imm};
  endfunction

endpackage

// File: rtl/pe_range_check.sv
module pe_range_check #(
  parameter int unsigned VALUE_W = 32,
  parameter int unsigned FIELD_W = 16
) (
  input  logic [VALUE_W-1:0] value,
  output logic               fits
);
  localparam int unsigned TOP_W = VALUE_W - FIELD_W + 1;

  logic [TOP_W-1:0] top_bits;

  always_comb begin
    top_bits = value[VALUE_W-1:FIELD_W-1];
    fits     = (&top_bits) | ~(|top_bits);
  end
endmodule

// File: rtl/pe_expander.sv
module pe_expander
  import pe_pkg::*;
(
  input  logic [KIND_W-1:0]             kind,
  input  logic [REG_W-1:0]              dst,
  input  logic [REG_W-1:0]              src,
  input  logic [INSN_W-1:0]             value,
  output logic [MAX_WORDS-1:0][INSN_W-1:0] words,
  output logic [CNT_W-1:0]              count,
  output logic                          bad
);
  logic               fits16;
  logic [IMM_W-1:0]   imm_lo;
  logic [IMM_W-1:0]   imm_hi;
  logic [SHAMT_W-1:0] amt;
  logic [SHAMT_W:0]   comp_full;
  logic [SHAMT_W-1:0] amt_comp;
  macro_kind_e        kind_e;

  pe_range_check #(.VALUE_W(INSN_W), .FIELD_W(IMM_W)) u_range (
    .value (value),
    .fits  (fits16)
  );

  always_comb begin
    imm_lo    = value[IMM_W-1:0];
    imm_hi    = value[INSN_W-1:IMM_W];
    amt       = value[SHAMT_W-1:0];
    comp_full = 6'd32 - {1'b0, amt};
    amt_comp  = comp_full[SHAMT_W-1:0];
    kind_e    = macro_kind_e'(kind);
  end

  always_comb begin
    words = '0;
    count = CNT_W'(1);
    bad   = 1'b0;
    case (kind_e)
      MK_NOP: begin
        words[0] = '0;
      end
      MK_MOVE: begin
        words[0] = enc_r(REG_ZERO, src, dst, '0, FN_ADD);
      end
      MK_LDIMM: begin
        if (fits16) begin
          words[0] = enc_i(OPC_ADDI, REG_ZERO, dst, imm_lo);
        end else begin
          words[0] = enc_i(OPC_LUI, REG_ZERO, dst, imm_hi);
          words[1] = enc_i(OPC_ORI, dst, dst, imm_lo);
          count    = CNT_W'(2);
        end
      end
      MK_ROTR: begin
        if (amt == '0) begin
          bad = 1'b1;
        end else begin
          words[0] = enc_r(REG_ZERO, dst, REG_SCRATCH, amt, FN_SRL);
          words[1] = enc_r(REG_ZERO, dst, dst, amt_comp, FN_SLL);
          words[2] = enc_r(dst, REG_SCRATCH, dst, '0, FN_OR);
          count    = CNT_W'(3);
        end
      end
      MK_ADDUI: begin
        if (fits16) begin
          words[0] = enc_i(OPC_ADDIU, src, dst, imm_lo);
        end else begin
          words[0] = enc_i(OPC_LUI, REG_ZERO, REG_SCRATCH, imm_hi);
          words[1] = enc_i(OPC_ORI, REG_SCRATCH, REG_SCRATCH, imm_lo);
          words[2] = enc_r(src, REG_SCRATCH, dst, '0, FN_ADDU);
          count    = CNT_W'(3);
        end
      end
      default: begin
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pe_emitter.sv
module pe_emitter
  import pe_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [MAX_WORDS-1:0][INSN_W-1:0]  load_words,
  input  logic [CNT_W-1:0]                  load_count,
  input  logic                              load_bad,
  output logic                              busy,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [INSN_W-1:0]                 out_word,
  output logic                              out_last,
  output logic                              err
);
  logic [MAX_WORDS-1:0][INSN_W-1:0] buf_q;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             err_q, err_d;
  logic             take;
  logic             at_end;

  genvar g;
  generate
    for (g = 0; g < MAX_WORDS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          buf_q[g] <= '0;
        end else if (load) begin
          buf_q[g] <= load_words[g];
        end
      end
    end
  endgenerate

  always_comb begin
    at_end = (idx_q == cnt_q - CNT_W'(1));
    take   = busy_q & out_ready;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    err_d  = 1'b0;
    if (load) begin
      idx_d  = '0;
      cnt_d  = load_count;
      busy_d = 1'b1;
      err_d  = load_bad;
    end else if (take) begin
      if (at_end) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= CNT_W'(1);
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    busy      = busy_q;
    out_valid = busy_q;
    out_word  = buf_q[idx_q];
    out_last  = busy_q & at_end;
    err       = err_q;
  end
endmodule

// File: rtl/pseudo_expander.sv
module pseudo_expander
  import pe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src,
  input  logic [INSN_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INSN_W-1:0] out_word,
  output logic              out_last,
  output logic              exp_error
);
  logic [MAX_WORDS-1:0][INSN_W-1:0] exp_words;
  logic [CNT_W-1:0]                 exp_count;
  logic                             exp_bad;
  logic                             busy;
  logic                             accept;

  pe_expander u_expand (
    .kind  (in_kind),
    .dst   (in_dst),
    .src   (in_src),
    .value (in_value),
    .words (exp_words),
    .count (exp_count),
    .bad   (exp_bad)
  );

  always_comb begin
    in_ready = ~busy;
    accept   = in_valid & ~busy;
  end

  pe_emitter u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_words (exp_words),
    .load_count (exp_count),
    .load_bad   (exp_bad),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .out_last   (out_last),
    .err        (exp_error)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_last,
  input logic        exp_error
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready));

  assert_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_err_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exp_error |=> !exp_error);

  assert_err_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exp_error |-> (out_valid && out_last && out_word == 32'h0));
endmodule

bind pseudo_expander pe_checker u_pe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_last  (out_last),
  .exp_error (exp_error)
);

// File: tb/tb_pseudo_expander.sv
module tb_pseudo_expander;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_kind;
  logic [4:0]  in_dst;
  logic [4:0]  in_src;
  logic [31:0] in_value;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_word;
  logic        out_last;
  logic        exp_error;

  int compared;
  int mismatched;

  pseudo_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_dst(in_dst), .in_src(in_src), .in_value(in_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last), .exp_error(exp_error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          st_kind[$];
  int          st_dst[$];
  int          st_src[$];
  logic [31:0] st_val[$];

  logic [31:0] q_word[$];
  string       q_tag[$];
  bit          m_err;

  task automatic add_macro(input int k, input int d, input int s, input logic [31:0] v);
    st_kind.push_back(k); st_dst.push_back(d); st_src.push_back(s); st_val.push_back(v);
  endtask

  function automatic logic [31:0] rw(input int rs, input int rt, input int rd, input int sh, input int fn);
    return (32'(rs) << 21) | (32'(rt) << 16) | (32'(rd) << 11) | (32'(sh) << 6) | 32'(fn);
  endfunction

  function automatic logic [31:0] iw(input int op, input int rs, input int rt, input int imm);
    return (32'(op) << 26) | (32'(rs) << 21) | (32'(rt) << 16) | (32'(imm) & 32'hFFFF);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model of one expansion, built from the requirement text.
  task automatic model_expand(input int k, input int d, input int s, input logic [31:0] v);
    int  sv;
    int  hi;
    int  lo;
    int  n;
    bit  fit;
    sv  = $signed(v);
    fit = (sv >= -32768) && (sv <= 32767);    // R11
    hi  = int'(v >> 16);
    lo  = int'(v & 32'hFFFF);
    n   = int'(v & 32'h1F);
    m_err = 1'b0;
    if (k == 0) begin
      q_word.push_back(32'h0); q_tag.push_back("R4");
    end else if (k == 1) begin
      q_word.push_back(rw(0, s, d, 0, 'h20)); q_tag.push_back("R5");
    end else if (k == 2 && fit) begin
      q_word.push_back(iw('h08, 0, d, lo)); q_tag.push_back("R6/R11");
    end else if (k == 2) begin
      q_word.push_back(iw('h0F, 0, d, hi)); q_tag.push_back("R7/R11");
      q_word.push_back(iw('h0D, d, d, lo)); q_tag.push_back("R7");
    end else if (k == 3 && n != 0) begin
      q_word.push_back(rw(0, d, 1, n, 'h02));             q_tag.push_back("R8");
      q_word.push_back(rw(0, d, d, (32 - n) % 32, 'h00)); q_tag.push_back("R8");
      q_word.push_back(rw(d, 1, d, 0, 'h25));             q_tag.push_back("R8");
    end else if (k == 4 && fit) begin
      q_word.push_back(iw('h09, s, d, lo)); q_tag.push_back("R9/R11");
    end else if (k == 4) begin
      q_word.push_back(iw('h0F, 0, 1, hi));  q_tag.push_back("R10/R11");
      q_word.push_back(iw('h0D, 1, 1, lo));  q_tag.push_back("R10");
      q_word.push_back(rw(s, 1, d, 0, 'h21)); q_tag.push_back("R10");
    end else begin
      q_word.push_back(32'h0); q_tag.push_back("R12");
      m_err = 1'b1;
    end
  endtask

  initial begin
    int idx;
    int cyc;
    bit exp_rdy;
    bit exp_vld;
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_dst = '0; in_src = '0;
    in_value = '0; out_ready = 1'b0;
    compared = 0; mismatched = 0; m_err = 1'b0;

    for (int pass = 0; pass < 2; pass++) begin
      add_macro(0, 0, 0, 32'h0);
      add_macro(1, 2, 5, 32'h0);
      add_macro(2, 8, 0, 32'd5);
      add_macro(2, 9, 0, 32'd32767);
      add_macro(2, 10, 0, 32'd32768);
      add_macro(2, 11, 0, -32'sd32768);
      add_macro(2, 12, 0, -32'sd32769);
      add_macro(2, 13, 0, 32'hABABCDCD);
      add_macro(3, 4, 0, 32'd7);
      add_macro(3, 4, 0, 32'd1);
      add_macro(3, 6, 0, 32'd31);
      add_macro(3, 4, 0, 32'd0);
      add_macro(3, 4, 0, 32'd32);
      add_macro(5, 3, 3, 32'd9);
      add_macro(6, 3, 3, 32'd9);
      add_macro(7, 3, 3, 32'd9);
      add_macro(4, 3, 7, 32'd40000);
      add_macro(4, 3, 7, 32'hFFFFFFFF);
      add_macro(4, 3, 7, 32'h12345678);
      add_macro(4, 20, 21, 32'd32767);
      add_macro(4, 20, 21, -32'sd32769);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state (R1)
    check(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);
    check(exp_error == 1'b0, "R12 reset exp_error", 32'(exp_error), 32'd0);
    rst_n = 1'b1;

    idx = 0;
    cyc = 0;
    while ((idx < st_kind.size() || q_word.size() > 0) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      exp_rdy = (q_word.size() == 0);
      exp_vld = !exp_rdy;
      check(in_ready == exp_rdy, "R1 in_ready", 32'(in_ready), 32'(exp_rdy));
      check(out_valid == exp_vld, "R1/R3 out_valid", 32'(out_valid), 32'(exp_vld));
      check(exp_error == (exp_vld && m_err), "R12 exp_error", 32'(exp_error), 32'(exp_vld && m_err));
      if (exp_vld) begin
        check(out_word == q_word[0], {q_tag[0], "/R2 out_word"}, out_word, q_word[0]);
        check(out_last == (q_word.size() == 1), "R3 out_last", 32'(out_last), 32'(q_word.size() == 1));
      end
      // drive
      in_valid  = (idx < st_kind.size()) && (cyc % 5 != 4);
      if (idx < st_kind.size()) begin
        in_kind  = 3'(st_kind[idx]);
        in_dst   = 5'(st_dst[idx]);
        in_src   = 5'(st_src[idx]);
        in_value = st_val[idx];
      end
      out_ready = (idx < st_kind.size() / 2) ? 1'b1 : !((cyc % 7 == 2) || (cyc % 7 == 3));
      @(posedge clk);
      // model update at the edge
      if (exp_vld) m_err = 1'b0;
      if (exp_vld && out_ready) begin
        void'(q_word.pop_front());
        void'(q_tag.pop_front());
      end else if (in_valid && exp_rdy) begin
        model_expand(st_kind[idx], st_dst[idx], st_src[idx], st_val[idx]);
        idx++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R3 final idle", 32'(out_valid), 32'd0);
    if (cyc >= 5000) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual %0d expected below 5000 cycles", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule